// File: doc/BRIEF.md
# Packet egress transmitter

The block stores whole packets written by an upstream producer and sends them to a downstream packet engine over a 32-bit word bus. The producer writes one word per accepted cycle with an end-of-packet marker on the last word. The block starts a packet only when the complete packet is buffered and the receiver has signalled that it can take a whole packet. Each word goes out with a word-valid enable, a one-cycle start-of-packet strobe on the first word, and an odd-parity bit that can be switched off.

Flow control works ahead of time. The receiver drives a packet-available line, which a configuration input can reinterpret as an active-high "full" line. The block registers that line once. Every cycle in which the registered level is high refills a budget of four words. While it is low, each word sent uses up one unit of the budget. A packet in flight pauses when the budget is empty and resumes without a new start strobe when the line comes back. When the line stays high and another complete packet is buffered, the next packet's first word follows the previous packet's last word with no idle cycle.

Top module: `pkt_egress_tx`

## Requirements
- R1: While reset is asserted, tx_en, tx_sop, tx_parity and all of tx_data are 0 and in_ready is 1.
- R2: Words leave on tx_data in the order they were accepted, bit for bit unchanged (bit 31 most significant).
- R3: tx_sop is high only together with tx_en, and only in the cycle that carries the first word of a packet.
- R4: tx_en is high only in cycles carrying an accepted word, and each accepted word appears exactly once.
- R5: With cfg_parity_en high, every word with tx_en high has an odd total count of ones across tx_data and tx_parity.
- R6: With cfg_parity_en low, tx_parity is 0.
- R7: The first word of a packet appears on the bus only if availability was high at the clock edge before the one that launches the word.
- R8: Once availability is sampled low, at most four words are launched on the following edges. After the drop, the bus shows the word already in flight plus four more, and then tx_en goes low.
- R9: With cfg_fc_full high, fc_in high means "full": no packet starts while it is high, and fc_in low lets transfers proceed.
- R10: With availability held high and the next complete packet buffered, the next packet's first word appears in the cycle after the previous packet's last word.
- R11: A packet paused by flow control resumes when availability returns, with no new tx_sop and no lost or repeated word.
- R12: in_ready is 0 when the buffer holds DEPTH words, and a word offered while in_ready is 0 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_parity_en | input | 1 | 1 enables odd parity on tx_parity |
| cfg_fc_full | input | 1 | 0: fc_in high means available; 1: fc_in high means full |
| fc_in | input | 1 | Flow-control line from the receiver |
| in_valid | input | 1 | Upstream word offered |
| in_data | input | 32 | Upstream word |
| in_eop | input | 1 | Marks the last word of a packet |
| in_ready | output | 1 | Buffer can accept a word this cycle |
| tx_data | output | 32 | Transmit word, registered |
| tx_parity | output | 1 | Odd parity over tx_data, or 0 when disabled |
| tx_sop | output | 1 | First word of a packet |
| tx_en | output | 1 | tx_data carries a valid word |

## Verification
A table of scenarios varies packet length from one to fifteen words, packet count, parity mode, flow-control polarity, and either steady or pseudo-random availability. This separates ordering errors from start-strobe placement and parity errors. Random drops test the four-word window under drops at arbitrary points inside packets. A directed drop right after a start strobe must yield exactly five further words, which tells a budget that is too long from one that is too short. Directed tests also cover back-to-back packets, which expose an idle bubble between packets. They cover a full buffer, which shows whether a word offered while full is dropped, and inverted polarity, which shows whether the line is read the wrong way round.

// File: rtl/pkt_egress_tx.sv
module pkt_egress_tx #(
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter int LOOKAHEAD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_parity_en,
  input  logic          cfg_fc_full,
  input  logic          fc_in,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_eop,
  output logic          in_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_parity,
  output logic          tx_sop,
  output logic          tx_en
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(LOOKAHEAD + 1);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] used, pkts;
  logic [BW-1:0] budget;
  logic          avail_q, in_pkt;

  logic [DW:0] head;
  logic        head_eop, wr, send, go_on;

  assign head     = mem[rd_ptr];
  assign head_eop = head[DW];
  assign in_ready = (used != CW'(DEPTH));
  assign wr       = in_valid && in_ready;
  assign go_on    = avail_q || (budget != '0);
  assign send     = in_pkt ? go_on : (avail_q && (pkts != '0));

  always_ff @(posedge clk) begin
    if (wr) mem[wr_ptr] <= {in_eop, in_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
      pkts   <= '0;
    end else begin
      if (wr)   wr_ptr <= wr_ptr + AW'(1);
      if (send) rd_ptr <= rd_ptr + AW'(1);
      case ({wr, send})
        2'b10:   used <= used + CW'(1);
        2'b01:   used <= used - CW'(1);
        default: ;
      endcase
      case ({wr && in_eop, send && head_eop})
        2'b10:   pkts <= pkts + CW'(1);
        2'b01:   pkts <= pkts - CW'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= 1'b0;
      budget  <= '0;
      in_pkt  <= 1'b0;
    end else begin
      avail_q <= fc_in ^ cfg_fc_full;
      if (avail_q)   budget <= BW'(LOOKAHEAD);
      else if (send) budget <= budget - BW'(1);
      if (send)      in_pkt <= !head_eop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data   <= '0;
      tx_parity <= 1'b0;
      tx_sop    <= 1'b0;
      tx_en     <= 1'b0;
    end else begin
      tx_en     <= send;
      tx_sop    <= send && !in_pkt;
      if (send) tx_data <= head[DW-1:0];
      tx_parity <= cfg_parity_en && (send ? ~^head[DW-1:0] : ~^tx_data);
    end
  end
endmodule

// File: rtl/pkt_egress_tx_chk.sv
module pkt_egress_tx_chk #(
  parameter int DW = 32,
  parameter int LOOKAHEAD = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_parity_en,
  input logic          cfg_fc_full,
  input logic          fc_in,
  input logic [DW-1:0] tx_data,
  input logic          tx_parity,
  input logic          tx_sop,
  input logic          tx_en
);
  logic       av1, av2;
  logic [3:0] low_words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      av1       <= 1'b0;
      av2       <= 1'b0;
      low_words <= '0;
    end else begin
      av1 <= fc_in ^ cfg_fc_full;
      av2 <= av1;
      if (av2)                                low_words <= '0;
      else if (tx_en && low_words != 4'hF)    low_words <= low_words + 4'd1;
    end
  end

  // R3
  sop_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop |-> tx_en);

  // R5
  odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(cfg_parity_en)) |-> (^{tx_data, tx_parity}));

  // R6
  parity_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_parity_en) |-> !tx_parity);

  // R7
  start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop |-> av2);

  // R8
  stop_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_words <= 4'(LOOKAHEAD));
endmodule

bind pkt_egress_tx pkt_egress_tx_chk #(.DW(DW), .LOOKAHEAD(LOOKAHEAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_parity_en(cfg_parity_en), .cfg_fc_full(cfg_fc_full),
  .fc_in(fc_in), .tx_data(tx_data), .tx_parity(tx_parity), .tx_sop(tx_sop), .tx_en(tx_en)
);

// File: tb/pkt_egress_tx_tb.sv
module pkt_egress_tx_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, cfg_parity_en, cfg_fc_full, fc_in, in_valid, in_eop, in_ready;
  logic [31:0] in_data, tx_data;
  logic        tx_parity, tx_sop, tx_en;

  bit rx_random, rx_dir, rx_rand;
  logic rx_avail;
  assign rx_avail = rx_random ? rx_rand : rx_dir;
  assign fc_in    = cfg_fc_full ? ~rx_avail : rx_avail;

  pkt_egress_tx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_parity_en(cfg_parity_en), .cfg_fc_full(cfg_fc_full),
    .fc_in(fc_in), .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop),
    .in_ready(in_ready), .tx_data(tx_data), .tx_parity(tx_parity), .tx_sop(tx_sop), .tx_en(tx_en)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_d [1024];
  bit exp_s [1024];
  bit exp_e [1024];
  int exp_wr = 0, exp_rd = 0;
  int cyc = 0, last_eop_cyc = 0, sop_gap = 0, low_words = 0;
  logic av_e0 = 0, av_e1 = 0;
  logic [15:0] lfsr = 16'hACE1;

  // {npkt[3:0], len[3:0], 1'b0, par_en, full_mode, random_rx}
  localparam logic [11:0] VEC [8] = '{
    {4'd1, 4'd1,  4'b0100},
    {4'd3, 4'd4,  4'b0100},
    {4'd2, 4'd12, 4'b0101},
    {4'd4, 4'd7,  4'b0001},
    {4'd3, 4'd5,  4'b0111},
    {4'd5, 4'd2,  4'b0110},
    {4'd2, 4'd15, 4'b0001},
    {4'd6, 4'd3,  4'b0101}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rx_rand = (lfsr[1:0] != 2'b00);
  end

  always @(posedge clk) begin
    av_e1 <= av_e0;
    av_e0 <= rx_avail;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!av_e1) low_words += int'(tx_en); else low_words = 0;
      if (!av_e1 && tx_en) chk(low_words <= 4, "R8", low_words, 4);
      if (tx_sop) begin
        chk(av_e1, "R7", av_e1, 1);
        chk(tx_en, "R3", tx_en, 1);
      end
      if (tx_en) begin
        if (exp_rd == exp_wr) chk(0, "R4", tx_data, 0);
        else begin
          chk(tx_data == exp_d[exp_rd], "R2", tx_data, exp_d[exp_rd]);
          chk(tx_sop == exp_s[exp_rd], "R3", tx_sop, exp_s[exp_rd]);
          if (cfg_parity_en) chk(^{tx_data, tx_parity}, "R5", tx_parity, ~^tx_data);
          else chk(tx_parity == 1'b0, "R6", tx_parity, 0);
          if (exp_s[exp_rd]) sop_gap = cyc - last_eop_cyc;
          if (exp_e[exp_rd]) last_eop_cyc = cyc;
          exp_rd++;
        end
      end
    end
  end

  task automatic push_pkt(input int len, input logic [7:0] tag, input logic [7:0] pn);
    for (int w = 0; w < len; w++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = {tag ^ 8'hC3, pn, 8'(w), ~8'(w * 29)};
      in_eop   = (w == len - 1);
      exp_d[exp_wr] = in_data;
      exp_s[exp_wr] = (w == 0);
      exp_e[exp_wr] = in_eop;
      exp_wr++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (exp_rd != exp_wr && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(exp_rd == exp_wr, req, exp_rd, exp_wr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    rst_n = 1'b0; cfg_parity_en = 1'b0; cfg_fc_full = 1'b0;
    in_valid = 1'b0; in_data = '0; in_eop = 1'b0;
    rx_random = 0; rx_dir = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tx_en && !tx_sop, "R1", {tx_en, tx_sop}, 0);
    chk(tx_data == 32'h0 && !tx_parity, "R1", tx_data, 0);
    chk(in_ready, "R1", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cfg_parity_en = VEC[i][2];
      cfg_fc_full   = VEC[i][1];
      rx_random     = VEC[i][0];
      rx_dir        = 1;
      for (int p = 0; p < int'(VEC[i][11:8]); p++)
        push_pkt(int'(VEC[i][7:4]), 8'(i * 37 + 5), 8'(p));
      drain("R2");
      rx_random = 0;
    end

    // R10 back-to-back
    @(negedge clk);
    cfg_parity_en = 1; cfg_fc_full = 0; rx_dir = 0;
    push_pkt(3, 8'h11, 8'd0);
    push_pkt(3, 8'h11, 8'd1);
    @(negedge clk);
    rx_dir = 1;
    drain("R10");
    chk(sop_gap == 1, "R10", sop_gap, 1);

    // R8 / R11 drop right after a start
    @(negedge clk);
    rx_dir = 0;
    push_pkt(12, 8'h22, 8'd0);
    @(negedge clk);
    rx_dir = 1;
    while (!tx_sop) @(negedge clk);
    rx_dir = 0;
    cnt = 0;
    repeat (10) begin
      @(negedge clk);
      cnt += int'(tx_en);
    end
    chk(cnt == 5, "R8", cnt, 5);
    chk(!tx_en, "R11", tx_en, 0);
    rx_dir = 1;
    drain("R11");

    // R9 inverted polarity
    @(negedge clk);
    cfg_fc_full = 1; rx_dir = 0;
    push_pkt(4, 8'h33, 8'd0);
    cnt = 0;
    repeat (10) begin
      @(negedge clk);
      cnt += int'(tx_en);
    end
    chk(fc_in == 1'b1, "R9", fc_in, 1);
    chk(cnt == 0, "R9", cnt, 0);
    rx_dir = 1;
    drain("R9");

    // R12 full buffer
    @(negedge clk);
    cfg_fc_full = 0; rx_dir = 0;
    push_pkt(8, 8'h44, 8'd0);
    push_pkt(8, 8'h44, 8'd1);
    chk(!in_ready, "R12", in_ready, 0);
    in_valid = 1'b1; in_data = 32'hDEAD_BEEF; in_eop = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0;
    rx_dir = 1;
    drain("R12");
    cnt = exp_rd;
    repeat (20) @(negedge clk);
    chk(exp_rd == cnt, "R12", exp_rd, cnt);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule